// File: doc/BRIEF.md
# DDR Memory-Bus Transaction Master

This block is the host end of a double-data-rate memory bus that uses one 8-bit data path. A local client hands it one request at a time: direction, address-space flag, burst type, a word address, one write word and a read length. The block then runs the bus transaction. It drops chip select and clocks out a 48-bit command/address word, one byte per clock edge, over three bus clocks. It lets a programmable number of latency clocks pass. It then moves 16-bit words. Write data is launched from the host clock. Read data is captured on the edges of the strobe that the memory returns.

The block runs from a system clock at twice the bus clock rate, so one system cycle is one half of a bus clock. The bus clock comes out as a true/complement pair. It only toggles while a transaction is active, and it changes half a system cycle after the data, so write and command bytes sit centred on its edges.

The request port is valid/ready. A request is taken on a clock where both are high. Ready stays low from that clock until the bus has been idle, with chip select high, for one full bus clock. While ready is low, a held request just waits. Read words come out on a valid-only port, one word per pulse, with no back-pressure: the consumer must take every word on the cycle it is flagged.

Top module: `ddr_membus_master`

## Requirements
- R1: While reset is held, and on the first cycle after it, chip select is high, the bus clock is low, the data output enable is low, done and read-valid are low and ready is high.
- R2: A request is taken on a cycle with valid and ready both high. Ready then stays low for the whole transaction, so a request held during that time is not taken.
- R3: The command/address phase lasts six system cycles with the output enable high. It sends the 48-bit word most significant byte first. Bit 47 is 1 for a read, bit 46 is the address-space flag, bit 45 is the burst flag (1 = linear), bits 44..16 are word-address bits 31..3, bits 2..0 are word-address bits 2..0, and bits 15..3 are zero.
- R4: Chip select falls while the bus clock is low. The clock's first edge is rising and falls in the middle of the first command byte. It changes once per system cycle through the command, latency and data phases, and it is low whenever chip select is high.
- R5: After the command phase, 2×L system cycles (L bus clocks, L taken from the latency input at acceptance) pass with the bus released before data. L = 0 goes straight to data.
- R6: A write moves exactly one word: bits 15..8 then bits 7..0, each for one system cycle, with the output enable high. The length field is ignored, and bit 45 is sent as 0 whatever the burst flag says.
- R7: A read of N words (a length of 0 counts as 1) gives 2×N clock edges with the bus released. A byte seen after a rising strobe edge is the high half and one seen after a falling edge is the low half. Each completed word comes out with one read-valid pulse on the cycle after its low byte is taken.
- R8: Chip select rises only while the bus clock is low, after the last complete word. Done pulses for exactly one cycle, on the first cycle that chip select is high again.
- R9: Ready returns only after chip select has been high for two system cycles (one bus clock).
- R10: The data output enable is high only during the command phase and the write-data phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the bus clock rate |
| rst | input | 1 | Synchronous reset, active high |
| cfg_latency | input | LAT_W | Latency bus clocks between command and data |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken |
| req_read | input | 1 | 1 = read, 0 = write |
| req_space | input | 1 | Address-space flag (1 = register space) |
| req_linear | input | 1 | Burst type, 1 = linear (reads only) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write word |
| req_len | input | LEN_W | Read length in words, 0 treated as 1 |
| rd_valid | output | 1 | Read word valid pulse |
| rd_data | output | 16 | Read word |
| done | output | 1 | One-cycle pulse at transaction end |
| cs_n | output | 1 | Chip select, active low |
| ck | output | 1 | Bus clock |
| ck_n | output | 1 | Complement bus clock |
| dq_o | output | 8 | Data bus drive value |
| dq_oe | output | 1 | Data bus output enable |
| dq_i | input | 8 | Data bus sampled value |
| rwds | input | 1 | Read data strobe from the memory |

## Verification
The bench goes after latency zero and after a long latency. A design that miscounted the latency window would shift every read byte by half a word, or would drive the bus into the memory. It sends writes with a length and the linear flag set; a design that honoured either would clock extra words or set bit 45. It runs reads of one word, of several words, and of length zero, and checks the final word, since a missing tail cycle would raise chip select before the last low byte lands. Requests are offered back to back, so a design that reopened ready too early, or let the clock run with chip select high, would show at once against the cycle-by-cycle model.

// File: rtl/ddrm_pkg.sv
`timescale 1ns/1ps
package ddrm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CA, ST_LAT, ST_WR, ST_RD, ST_TAIL, ST_GAP
  } phase_e;

  localparam int CA_W      = 48;
  localparam int CA_BYTES  = CA_W / 8;
  localparam int UPPER_W   = 29;
  localparam int LOWER_W   = 3;
  localparam int PAD_W     = CA_W - 3 - UPPER_W - LOWER_W;
  localparam int GAP_CYC   = 2;
  localparam int TAIL_MAX  = 2;
endpackage

// File: rtl/ddrm_ca_pack.sv
`timescale 1ns/1ps
module ddrm_ca_pack
  import ddrm_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              is_read,
  input  logic              in_reg,
  input  logic              linear,
  input  logic [ADDR_W-1:0] addr,
  output logic [CA_W-1:0]   ca
);
  localparam int HI_W = ADDR_W - LOWER_W;

  logic [UPPER_W-1:0] upper;
  assign upper = UPPER_W'(addr[ADDR_W-1:LOWER_W]);

  // burst flag only carried for reads
  assign ca = {is_read, in_reg, is_read & linear, upper,
               {PAD_W{1'b0}}, addr[LOWER_W-1:0]};

  initial begin
    assert (HI_W <= UPPER_W) else $error("address too wide for command word");
  end
endmodule

// File: rtl/ddrm_ck_gen.sv
`timescale 1ns/1ps
module ddrm_ck_gen (
  input  logic clk,
  input  logic rst,
  input  logic run_hi,
  output logic ck,
  output logic ck_n
);
  logic ck_q;

  // falling-edge launch puts the bus clock edge mid-way through each byte
  always_ff @(negedge clk) begin
    if (rst) ck_q <= 1'b0;
    else     ck_q <= run_hi;
  end

  assign ck   = ck_q;
  assign ck_n = ~ck_q;
endmodule

// File: rtl/ddrm_rd_capture.sv
`timescale 1ns/1ps
module ddrm_rd_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              arm,
  input  logic              rwds,
  input  logic [BYTE_W-1:0] dq_i,
  output logic              word_done,
  output logic              rd_valid,
  output logic [2*BYTE_W-1:0] rd_data
);
  logic              rwds_q;
  logic [BYTE_W-1:0] hi_q;
  logic              strobe_edge;

  assign strobe_edge = arm && (rwds != rwds_q);
  assign word_done   = strobe_edge && !rwds;

  always_ff @(posedge clk) begin
    if (rst) begin
      rwds_q   <= 1'b0;
      hi_q     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rwds_q   <= rwds;
      rd_valid <= word_done;
      if (strobe_edge && rwds) hi_q <= dq_i;
      if (word_done) rd_data <= {hi_q, dq_i};
    end
  end

  // R7: a word is only reported after a falling strobe seen while armed
  assert_word_after_fall_R7: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> ($past(arm) && !$past(rwds)));
endmodule

// File: rtl/ddr_membus_master.sv
`timescale 1ns/1ps
module ddr_membus_master
  import ddrm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_read,
  input  logic              req_space,
  input  logic              req_linear,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [LEN_W-1:0]  req_len,
  output logic              rd_valid,
  output logic [15:0]       rd_data,
  output logic              done,
  output logic              cs_n,
  output logic              ck,
  output logic              ck_n,
  output logic [7:0]        dq_o,
  output logic              dq_oe,
  input  logic [7:0]        dq_i,
  input  logic              rwds
);
  localparam int CNT_W = ((LEN_W > LAT_W) ? LEN_W : LAT_W) + 2;

  phase_e           st;
  logic [CNT_W-1:0] half;
  logic [CA_W-1:0]  ca_q;
  logic [CA_W-1:0]  ca_next;
  logic [15:0]      wd_q;
  logic [LEN_W-1:0] len_q;
  logic [LEN_W-1:0] words;
  logic [LAT_W-1:0] lat_q;
  logic             rd_q;
  logic             word_done;
  logic             ck_run;
  logic             arm;
  logic [CNT_W-1:0] lat_end;
  logic [CNT_W-1:0] rd_end;
  phase_e           data_st;

  ddrm_ca_pack #(.ADDR_W(ADDR_W)) u_pack (
    .is_read (req_read),
    .in_reg  (req_space),
    .linear  (req_linear),
    .addr    (req_addr),
    .ca      (ca_next)
  );

  assign lat_end = (CNT_W'(lat_q) << 1) - CNT_W'(1);
  assign rd_end  = (CNT_W'(len_q) << 1) - CNT_W'(1);
  assign data_st = rd_q ? ST_RD : ST_WR;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      half  <= '0;
      ca_q  <= '0;
      wd_q  <= '0;
      len_q <= '0;
      words <= '0;
      lat_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            ca_q  <= ca_next;
            wd_q  <= req_wdata;
            len_q <= (req_len == '0) ? LEN_W'(1) : req_len;
            lat_q <= cfg_latency;
            rd_q  <= req_read;
            half  <= '0;
            words <= '0;
            st    <= ST_CA;
          end
        end
        ST_CA: begin
          ca_q <= ca_q << 8;
          if (half == CNT_W'(CA_BYTES - 1)) begin
            half <= '0;
            st   <= (lat_q == '0) ? data_st : ST_LAT;
          end else begin
            half <= half + CNT_W'(1);
          end
        end
        ST_LAT: begin
          if (half == lat_end) begin
            half <= '0;
            st   <= data_st;
          end else begin
            half <= half + CNT_W'(1);
          end
        end
        ST_WR: begin
          if (half == CNT_W'(1)) begin
            half <= '0;
            st   <= ST_GAP;
          end else begin
            half <= half + CNT_W'(1);
          end
        end
        ST_RD: begin
          words <= words + LEN_W'(word_done);
          if (half == rd_end) begin
            half <= '0;
            st   <= ST_TAIL;
          end else begin
            half <= half + CNT_W'(1);
          end
        end
        ST_TAIL: begin
          words <= words + LEN_W'(word_done);
          if (words == len_q || half == CNT_W'(TAIL_MAX)) begin
            half <= '0;
            st   <= ST_GAP;
          end else begin
            half <= half + CNT_W'(1);
          end
        end
        ST_GAP: begin
          if (half == CNT_W'(GAP_CYC - 1)) begin
            half <= '0;
            st   <= ST_IDLE;
          end else begin
            half <= half + CNT_W'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ck_run = ((st == ST_CA) || (st == ST_LAT) || (st == ST_WR) || (st == ST_RD))
                  && !half[0];
  assign arm    = (st == ST_RD) || (st == ST_TAIL);

  ddrm_ck_gen u_ck (
    .clk    (clk),
    .rst    (rst),
    .run_hi (ck_run),
    .ck     (ck),
    .ck_n   (ck_n)
  );

  ddrm_rd_capture #(.BYTE_W(8)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .arm       (arm),
    .rwds      (rwds),
    .dq_i      (dq_i),
    .word_done (word_done),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_comb begin
    dq_o = '0;
    if (st == ST_CA)      dq_o = ca_q[CA_W-1 -: 8];
    else if (st == ST_WR) dq_o = half[0] ? wd_q[7:0] : wd_q[15:8];
  end

  assign cs_n      = (st == ST_IDLE) || (st == ST_GAP);
  assign dq_oe     = (st == ST_CA) || (st == ST_WR);
  assign done      = (st == ST_GAP) && (half == '0);
  assign req_ready = (st == ST_IDLE);

  assert_cs_rise_ck_low_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !ck);
  assert_ck_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n)) |-> !ck);
  assert_bus_released_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !dq_oe);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_ready_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (req_ready && !$past(req_ready)) |-> ($past(cs_n) && $past(cs_n, 2)));
  assert_busy_after_take_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/ddr_membus_master_bench.sv
`timescale 1ns/1ps
module ddr_membus_master_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  cfg_latency = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_read = 1'b0;
  logic        req_space = 1'b0;
  logic        req_linear = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0]  req_len = '0;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic        done;
  logic        cs_n, ck, ck_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = '0;
  logic        rwds = 1'b0;

  int checks = 0;
  int errors = 0;
  bit running = 1'b0;

  always #10 clk = ~clk;

  ddr_membus_master u_ddr_membus_master (
    .clk(clk), .rst(rst), .cfg_latency(cfg_latency),
    .req_valid(req_valid), .req_ready(req_ready), .req_read(req_read),
    .req_space(req_space), .req_linear(req_linear), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_len(req_len), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .cs_n(cs_n), .ck(ck), .ck_n(ck_n),
    .dq_o(dq_o), .dq_oe(dq_oe), .dq_i(dq_i), .rwds(rwds)
  );

  typedef struct {
    bit          cs_n;
    bit          ck;
    bit          oe;
    logic [7:0]  dq;
    bit          rdv;
    logic [15:0] rdd;
    bit          done;
    bit          ready;
    string       tag;
  } exp_t;

  exp_t q[$];

  // bench memory contents
  function automatic logic [15:0] dev_word(input logic [31:0] a, input int k);
    return (a[15:0] ^ 16'h5A3C) + 16'(k * 16'h1021);
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic exp_t mk(input bit c, input bit k, input bit o, input string t);
    exp_t e;
    e.cs_n = c; e.ck = k; e.oe = o; e.dq = '0; e.rdv = 1'b0; e.rdd = '0;
    e.done = 1'b0; e.ready = 1'b0; e.tag = t;
    return e;
  endfunction

  // device-side state shared with the model
  bit          cur_read;
  logic [31:0] cur_addr;
  int          cur_len;
  int          cur_lat;

  task automatic build();
    logic [47:0] ca;
    exp_t e;
    int n;
    int lat;
    n   = (req_len == 0) ? 1 : int'(req_len);
    lat = int'(cfg_latency);
    ca  = {req_read, req_space, req_read & req_linear, req_addr[31:3], 13'b0, req_addr[2:0]};
    cur_read = req_read; cur_addr = req_addr; cur_len = n; cur_lat = lat;
    for (int i = 0; i < 6; i++) begin
      e = mk(1'b0, (i % 2) == 0, 1'b1, "R3");
      e.dq = ca[47 - 8*i -: 8];
      q.push_back(e);
    end
    for (int j = 0; j < 2*lat; j++) q.push_back(mk(1'b0, (j % 2) == 0, 1'b0, "R5"));
    if (!req_read) begin
      e = mk(1'b0, 1'b1, 1'b1, "R6"); e.dq = req_wdata[15:8]; q.push_back(e);
      e = mk(1'b0, 1'b0, 1'b1, "R6"); e.dq = req_wdata[7:0];  q.push_back(e);
    end else begin
      for (int h = 0; h < 2*n; h++) begin
        e = mk(1'b0, (h % 2) == 0, 1'b0, "R7");
        if (h >= 2 && (h % 2) == 0) begin
          e.rdv = 1'b1; e.rdd = dev_word(req_addr, h/2 - 1);
        end
        q.push_back(e);
      end
      e = mk(1'b0, 1'b0, 1'b0, "R7");
      e.rdv = 1'b1; e.rdd = dev_word(req_addr, n - 1);
      q.push_back(e);
    end
    e = mk(1'b1, 1'b0, 1'b0, "R8"); e.done = 1'b1; q.push_back(e);
    q.push_back(mk(1'b1, 1'b0, 1'b0, "R9"));
  endtask

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #15;
    if (running) begin
      exp_t e;
      if (q.size() > 0) e = q.pop_front();
      else begin e = mk(1'b1, 1'b0, 1'b0, "R2"); e.ready = 1'b1; end
      chk("R8", "cs_n", cs_n, e.cs_n);
      chk("R4", "ck", ck, e.ck);
      chk("R4", "ck_n", ck_n, !e.ck);
      chk((e.tag == "R5" || e.tag == "R7") ? e.tag : "R10", "dq_oe", dq_oe, e.oe);
      if (e.oe) chk(e.tag, "dq_o", dq_o, e.dq);
      chk("R7", "rd_valid", rd_valid, e.rdv);
      if (e.rdv) chk("R7", "rd_data", rd_data, e.rdd);
      chk("R8", "done", done, e.done);
      chk((e.tag == "R9") ? "R9" : "R2", "req_ready", req_ready, e.ready);
      if (e.ready && req_valid) build();
    end
  end

  // memory model: answers read data on the bus clock edges, strobe aligned
  int  edge_cnt = 0;
  bit  prev_ck = 1'b0;
  always @(negedge clk) begin
    #1;
    if (cs_n) begin
      edge_cnt = 0; prev_ck = 1'b0; rwds = 1'b0;
    end else if (ck != prev_ck) begin
      int d;
      prev_ck = ck;
      d = edge_cnt - 6 - 2*cur_lat;
      edge_cnt++;
      if (cur_read && d >= 0 && d < 2*cur_len) begin
        logic [15:0] w;
        w = dev_word(cur_addr, d/2);
        rwds = (d % 2) == 0;
        dq_i = ((d % 2) == 0) ? w[15:8] : w[7:0];
      end
    end
  end

  task automatic send(input bit rd, input bit sp, input bit lin, input logic [31:0] a,
                      input logic [15:0] wd, input logic [7:0] ln, input logic [3:0] lat);
    bit acc;
    @(posedge clk); #5;
    req_read = rd; req_space = sp; req_linear = lin; req_addr = a;
    req_wdata = wd; req_len = ln; cfg_latency = lat; req_valid = 1'b1;
    do begin
      #7; acc = req_ready;
      @(posedge clk); #5;
    end while (!acc);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #15;
    // R1: reset state
    chk("R1", "cs_n", cs_n, 1);
    chk("R1", "ck", ck, 0);
    chk("R1", "dq_oe", dq_oe, 0);
    chk("R1", "done", done, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "req_ready", req_ready, 1);
    @(posedge clk); #5; rst = 1'b0;
    @(posedge clk); running = 1'b1;
    // R6: write with length and linear flag set, both ignored
    send(1'b0, 1'b0, 1'b1, 32'h1234_5677, 16'hBEEF, 8'd5, 4'd2);
    // R7: three-word linear read in register space, R2 back to back
    send(1'b1, 1'b1, 1'b1, 32'h0000_0A05, 16'h0, 8'd3, 4'd2);
    // R5: zero latency read of one word at top of address range
    send(1'b1, 1'b0, 1'b0, 32'hFFFF_FFF8, 16'h0, 8'd1, 4'd0);
    // R5/R6: zero latency write
    send(1'b0, 1'b1, 1'b0, 32'h0000_0003, 16'h8001, 8'd0, 4'd0);
    // R7: length zero counts as one, long latency, wrapped burst
    send(1'b1, 1'b0, 1'b0, 32'h00C0_FFEE, 16'h0, 8'd0, 4'd6);
    // R7: four words, single latency clock
    send(1'b1, 1'b0, 1'b1, 32'h7654_3210, 16'h0, 8'd4, 4'd1);
    repeat (60) @(posedge clk);
    #16;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule